// File: doc/BRIEF.md
# Ring-Chained FIFO Slice

This block is one slice of a deep first-in first-out buffer that is built by chaining identical slices in a ring. Each slice wraps a small storage array with its own write and read pointers. Two tokens circulate around the ring. The slice that holds the write token accepts writes, and the slice that holds the read token supplies reads. Write enable, read enable, write data and output enable are common to every slice. The read data outputs of all slices are ORed into one bus.

A slice gives up the write token after it writes its last physical location. It does this by raising its write-expansion output for one clock, and the next slice samples that pulse on its write-expansion input. The read token moves the same way, through the read-expansion output and input. The outputs of the last slice feed the inputs of the first slice, which closes the ring. A strap picks the one slice that holds both tokens after reset. When a slice is not in a chain, a mode input makes it keep both tokens permanently, and the shared write-expansion pin then carries an active-low half-full flag.

Every slice gives active-low empty, full, almost-empty and almost-full flags for its own contents. The chain-level flag is the OR of the matching flags of all slices. A single clock serves both ports.

Top module: `cfs_slice`

## Requirements
- R1: During and after reset, a slice with `first_load_n` low holds both tokens and a slice with it high holds neither. All flags show empty, and `rd_data` reads zero.
- R2: A write is taken only while the slice holds the write token and is not full. A slice in cascade mode that samples `wxi` high on a clock edge holds the write token from that edge on.
- R3: In cascade mode, a write to location DEPTH-1 releases the write token at that edge. `hf_wxo` is then high for exactly the following clock cycle and low otherwise.
- R4: In cascade mode, a read from location DEPTH-1 releases the read token at that edge. `rxo` is then high for exactly the following cycle. A slice takes the read token on the edge that samples `rxi` high.
- R5: Words come out of the chain in the order they were written, across slice boundaries and around the ring. The word read on an edge appears on `rd_data` in the cycle after that edge.
- R6: `rd_data` is nonzero only when `oe` is 1 and the slice either holds the read token or has `rxo` high. Otherwise it is all zeros. While it drives, it shows the last word this slice read, and a read that is not taken leaves that word unchanged.
- R7: `empty_n` is low exactly when the slice holds 0 words, and `full_n` is low exactly when it holds DEPTH words. A write to a full slice and a read from an empty slice are ignored.
- R8: `almost_empty_n` is low when the count is at most AE_OFF. `almost_full_n` is low when the count is at least DEPTH-AF_OFF.
- R9: With `cascade_en` at 0 the slice holds both tokens at all times and `rxo` stays 0. `hf_wxo` is an active-low half-full flag that is low when the count exceeds DEPTH/2.
- R10: In a ring of N slices, after DEPTH*N accepted writes the write token is back at the strapped slice. After DEPTH*N accepted reads the read token is back there too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| first_load_n | input | 1 | Strap; low marks the slice that starts with both tokens |
| cascade_en | input | 1 | 1 = ring member, 0 = standalone |
| wr_en | input | 1 | Write request, shared by the chain |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read request, shared by the chain |
| oe | input | 1 | Output enable for the read data |
| wxi | input | 1 | Write-token pulse from the previous slice |
| rxi | input | 1 | Read-token pulse from the previous slice |
| rd_data | output | W | Gated read data; zero when not driving |
| hf_wxo | output | 1 | Write-token pulse in cascade mode, active-low half-full standalone |
| rxo | output | 1 | Read-token pulse to the next slice |
| wr_token | output | 1 | Slice currently holds the write token |
| rd_token | output | 1 | Slice currently holds the read token |
| empty_n | output | 1 | Low when the slice is empty |
| full_n | output | 1 | Low when the slice is full |
| almost_empty_n | output | 1 | Low when count is at most AE_OFF |
| almost_full_n | output | 1 | Low when count is at least DEPTH-AF_OFF |

## Verification
Three slices of depth four are wired in a ring. The ring is first filled to capacity and then drained completely, which walks both tokens through every slice and around the ring back to the start. A write is then tried on the full chain and a read on the empty chain, which separates a slice that blocks these from one that corrupts its pointers or its held output word. A long interleaved mix of writes and reads follows, with the write token and the read token in different slices, which tells correct per-slice counts and data order apart from logic that only works when one slice does all the work. A read with output enable off, and a standalone slice, check the bus gating and the half-full threshold apart from the token path.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef struct packed {
        logic held;
        logic pulse;
    } cfs_tok_t;
endpackage

// File: rtl/cfs_token.sv
module cfs_token
    import cfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_held,
    input  logic cascade_en,
    input  logic take,
    input  logic fire,
    input  logic at_last,
    output logic held,
    output logic pulse
);
    cfs_tok_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!cascade_en) begin
            st_d.held = 1'b1;
        end else if (fire && at_last) begin
            st_d.held  = 1'b0;
            st_d.pulse = 1'b1;
        end else if (take) begin
            st_d.held = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.held  <= start_held;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held  = st_q.held;
    assign pulse = st_q.pulse;
endmodule

// File: rtl/cfs_level.sv
module cfs_level #(
    parameter int DEPTH  = 4,
    parameter int AE_OFF = 1,
    parameter int AF_OFF = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_fire,
    input  logic                       rd_fire,
    output logic [$clog2(DEPTH)-1:0]   waddr,
    output logic [$clog2(DEPTH)-1:0]   raddr,
    output logic                       wr_last,
    output logic                       rd_last,
    output logic                       empty_n,
    output logic                       full_n,
    output logic                       ae_n,
    output logic                       af_n,
    output logic                       hf_n
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] count;
    } lvl_t;

    lvl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_fire) st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        if (rd_fire) st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        case ({wr_fire, rd_fire})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr   = st_q.wptr;
    assign raddr   = st_q.rptr;
    assign wr_last = (st_q.wptr == LAST);
    assign rd_last = (st_q.rptr == LAST);
    assign empty_n = (st_q.count != '0);
    assign full_n  = (st_q.count != CW'(DEPTH));
    assign ae_n    = (st_q.count > CW'(AE_OFF));
    assign af_n    = (st_q.count < CW'(DEPTH - AF_OFF));
    assign hf_n    = (st_q.count <= CW'(DEPTH / 2));
endmodule

// File: rtl/cfs_store.sv
module cfs_store #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_fire,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wr_data,
    input  logic                     rd_fire,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             q
);
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] q_d, q_q;

    always_ff @(posedge clk) begin
        if (wr_fire) mem[waddr] <= wr_data;
    end

    always_comb begin
        q_d = q_q;
        if (rd_fire) q_d = mem[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/cfs_slice.sv
module cfs_slice #(
    parameter int W      = 8,
    parameter int DEPTH  = 4,
    parameter int AE_OFF = 1,
    parameter int AF_OFF = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         first_load_n,
    input  logic         cascade_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         oe,
    input  logic         wxi,
    input  logic         rxi,
    output logic [W-1:0] rd_data,
    output logic         hf_wxo,
    output logic         rxo,
    output logic         wr_token,
    output logic         rd_token,
    output logic         empty_n,
    output logic         full_n,
    output logic         almost_empty_n,
    output logic         almost_full_n
);
    localparam int PW = $clog2(DEPTH);

    logic          wr_held, rd_held, wr_pulse, rd_pulse;
    logic          wr_fire, rd_fire, wr_last, rd_last, hf_n;
    logic          lv_empty_n, lv_full_n;
    logic [PW-1:0] waddr, raddr;
    logic [W-1:0]  q;
    logic          start_held;

    assign start_held = !first_load_n || !cascade_en;
    assign wr_fire    = wr_en && wr_held && lv_full_n;
    assign rd_fire    = rd_en && rd_held && lv_empty_n;

    cfs_token u_wtok (
        .clk(clk), .rst_n(rst_n), .start_held(start_held), .cascade_en(cascade_en),
        .take(wxi), .fire(wr_fire), .at_last(wr_last), .held(wr_held), .pulse(wr_pulse)
    );

    cfs_token u_rtok (
        .clk(clk), .rst_n(rst_n), .start_held(start_held), .cascade_en(cascade_en),
        .take(rxi), .fire(rd_fire), .at_last(rd_last), .held(rd_held), .pulse(rd_pulse)
    );

    cfs_level #(.DEPTH(DEPTH), .AE_OFF(AE_OFF), .AF_OFF(AF_OFF)) u_level (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .waddr(waddr), .raddr(raddr), .wr_last(wr_last), .rd_last(rd_last),
        .empty_n(lv_empty_n), .full_n(lv_full_n), .ae_n(almost_empty_n),
        .af_n(almost_full_n), .hf_n(hf_n)
    );

    cfs_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .waddr(waddr), .wr_data(wr_data),
        .rd_fire(rd_fire), .raddr(raddr), .q(q)
    );

    assign rd_data  = (oe && (rd_held || rd_pulse)) ? q : '0;
    assign hf_wxo   = cascade_en ? wr_pulse : hf_n;
    assign rxo      = rd_pulse;
    assign wr_token = wr_held;
    assign rd_token = rd_held;
    assign empty_n  = lv_empty_n;
    assign full_n   = lv_full_n;
endmodule

// File: rtl/cfs_slice_chk.sv
module cfs_slice_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cascade_en,
    input logic         wr_en,
    input logic         rd_en,
    input logic         oe,
    input logic         wxi,
    input logic [W-1:0] rd_data,
    input logic         hf_wxo,
    input logic         rxo,
    input logic         wr_token,
    input logic         rd_token,
    input logic         empty_n,
    input logic         full_n,
    input logic         almost_full_n
);
    AST_WXO_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_en && hf_wxo |=> !hf_wxo); // R3
    AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_en && $fell(wr_token) |-> hf_wxo); // R3
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_token) |-> rxo); // R4
    AST_RXO_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rxo |=> !rxo); // R4
    AST_WR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_en && wxi |=> wr_token); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n && !rd_en |=> !full_n); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n && !wr_en |=> !empty_n); // R7
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !oe || (!rd_token && !rxo) |-> rd_data == '0); // R6
    AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n && empty_n); // R8
endmodule

bind cfs_slice cfs_slice_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cascade_en(cascade_en), .wr_en(wr_en), .rd_en(rd_en),
    .oe(oe), .wxi(wxi), .rd_data(rd_data), .hf_wxo(hf_wxo), .rxo(rxo),
    .wr_token(wr_token), .rd_token(rd_token), .empty_n(empty_n), .full_n(full_n),
    .almost_full_n(almost_full_n)
);

// File: tb/cfs_slice_tb.sv
`timescale 1ns/1ps
module cfs_slice_tb;
    localparam int W = 8, DEPTH = 4, N = 3, AE = 1, AF = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, oe = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic s_wr = 1'b0, s_rd = 1'b0;

    logic [W-1:0] rdat [N];
    logic [N-1:0] wxo, rxo, wtok, rtok, e_n, f_n, ae_n, af_n;
    logic [W-1:0] s_data;
    logic s_hf, s_rxo, s_wtok, s_rtok, s_e, s_f, s_ae, s_af;

    always #4 clk = ~clk;

    cfs_slice #(.W(W), .DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF)) u_dut (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b0), .cascade_en(1'b1),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .oe(oe),
        .wxi(wxo[2]), .rxi(rxo[2]), .rd_data(rdat[0]), .hf_wxo(wxo[0]), .rxo(rxo[0]),
        .wr_token(wtok[0]), .rd_token(rtok[0]), .empty_n(e_n[0]), .full_n(f_n[0]),
        .almost_empty_n(ae_n[0]), .almost_full_n(af_n[0]));
    cfs_slice #(.W(W), .DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF)) u_s1 (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b1), .cascade_en(1'b1),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .oe(oe),
        .wxi(wxo[0]), .rxi(rxo[0]), .rd_data(rdat[1]), .hf_wxo(wxo[1]), .rxo(rxo[1]),
        .wr_token(wtok[1]), .rd_token(rtok[1]), .empty_n(e_n[1]), .full_n(f_n[1]),
        .almost_empty_n(ae_n[1]), .almost_full_n(af_n[1]));
    cfs_slice #(.W(W), .DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF)) u_s2 (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b1), .cascade_en(1'b1),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .oe(oe),
        .wxi(wxo[1]), .rxi(rxo[1]), .rd_data(rdat[2]), .hf_wxo(wxo[2]), .rxo(rxo[2]),
        .wr_token(wtok[2]), .rd_token(rtok[2]), .empty_n(e_n[2]), .full_n(f_n[2]),
        .almost_empty_n(ae_n[2]), .almost_full_n(af_n[2]));
    cfs_slice #(.W(W), .DEPTH(DEPTH), .AE_OFF(AE), .AF_OFF(AF)) u_solo (
        .clk(clk), .rst_n(rst_n), .first_load_n(1'b1), .cascade_en(1'b0),
        .wr_en(s_wr), .wr_data(wr_data), .rd_en(s_rd), .oe(1'b1),
        .wxi(1'b0), .rxi(1'b0), .rd_data(s_data), .hf_wxo(s_hf), .rxo(s_rxo),
        .wr_token(s_wtok), .rd_token(s_rtok), .empty_n(s_e), .full_n(s_f),
        .almost_empty_n(s_ae), .almost_full_n(s_af));

    wire [W-1:0] bus = rdat[0] | rdat[1] | rdat[2];

    int checks = 0, errors = 0;
    bit done = 0;
    int cnt [N];
    int lastq [N];
    int wsel = 0, rsel = 0, wpos = 0, rpos = 0;
    int fq [64];
    int head = 0, tail = 0, seq = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        int total = 0;
        for (int i = 0; i < N; i++) begin
            total += cnt[i];
            check({tag, " R7 empty_n"}, e_n[i], cnt[i] != 0);
            check({tag, " R7 full_n"}, f_n[i], cnt[i] != DEPTH);
            check({tag, " R8 ae_n"}, ae_n[i], cnt[i] > AE);
            check({tag, " R8 af_n"}, af_n[i], cnt[i] < DEPTH - AF);
            check({tag, " R2 wr_token"}, wtok[i], wsel == i);
            check({tag, " R4 rd_token"}, rtok[i], rsel == i);
        end
        check({tag, " chain empty OR"}, |e_n, total != 0);
        check({tag, " chain full OR"}, |f_n, total != N * DEPTH);
        check({tag, " R6 held bus"}, bus, oe ? lastq[rsel] : 0);
    endtask

    task automatic do_write(int d);
        bit acc;
        int ws, wp;
        ws = wsel; wp = wpos;
        acc = (cnt[wsel] < DEPTH);
        @(negedge clk); wr_en = 1'b1; wr_data = W'(d);
        @(negedge clk); wr_en = 1'b0;
        for (int i = 0; i < N; i++)
            check("R3 wxo pulse", wxo[i], acc && ws == i && wp == DEPTH - 1);
        if (acc) begin
            cnt[wsel]++; fq[tail] = d & 255; tail = (tail + 1) % 64;
            wpos++;
            if (wpos == DEPTH) begin wpos = 0; wsel = (wsel + 1) % N; end
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) check("R3 wxo low after", wxo[i], 0);
        check_state("write");
    endtask

    task automatic do_read();
        bit acc;
        int rs, rp;
        rs = rsel; rp = rpos;
        acc = (cnt[rsel] > 0);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        for (int i = 0; i < N; i++)
            check("R4 rxo pulse", rxo[i], acc && rs == i && rp == DEPTH - 1);
        if (acc) begin
            check("R5 order", bus, oe ? fq[head] : 0);
            lastq[rsel] = fq[head]; head = (head + 1) % 64;
            cnt[rsel]--; rpos++;
            if (rpos == DEPTH) begin rpos = 0; rsel = (rsel + 1) % N; end
        end else begin
            check("R7 underflow hold", bus, oe ? lastq[rsel] : 0);
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) check("R4 rxo low after", rxo[i], 0);
        check_state("read");
    endtask

    function automatic int next_word();
        seq++;
        return (seq * 37 + 11) & 255;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin cnt[i] = 0; lastq[i] = 0; end
        repeat (3) @(negedge clk);
        check_state("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after reset");
        check("R9 solo tokens", {s_wtok, s_rtok}, 3);

        // fill the ring, then overrun
        for (int k = 0; k < N * DEPTH; k++) do_write(next_word());
        check("R10 write token home", wtok, 3'b001);
        do_write(next_word());
        // drain, then underrun
        for (int k = 0; k < N * DEPTH; k++) do_read();
        check("R10 read token home", rtok, 3'b001);
        do_read();

        // interleaved mix around the ring
        for (int k = 0; k < 90; k++) begin
            if (((k * 7) % 5) < 3) do_write(next_word());
            else do_read();
        end

        // output enable off during a read, then back on
        do_write(next_word());
        oe = 1'b0;
        do_read();
        oe = 1'b1;
        @(negedge clk);
        check("R6 oe restored", bus, lastq[rsel]);
        while (head != tail) do_read();

        // standalone slice: half-full and order
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); s_wr = 1'b1; wr_data = W'(8'h40 + k);
            @(negedge clk); s_wr = 1'b0;
            check("R9 half-full", s_hf, (k + 1) <= DEPTH / 2);
            check("R9 solo tokens held", {s_wtok, s_rtok}, 3);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); s_rd = 1'b1;
            @(negedge clk); s_rd = 1'b0;
            check("R9 solo order", s_data, 8'h40 + k);
            check("R9 solo rxo", s_rxo, 0);
        end
        check("R9 solo empty", s_e, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule